// File: doc/BRIEF.md
# Shared Byte Store with Two-Client Priority Arbiter

This block is a small shared memory. Two client modules use it to pass byte-wide variables to each other. Each client has its own request/acknowledge pair, a read/write select, an address, write data and read data. A fixed-priority Moore state machine decides which client gets the single-port storage array. Only one word moves per grant.

The arbiter waits in an idle state until a request arrives. If both clients ask in the same cycle, the second client (B) wins. On the clock edge that grants a client, the controller performs that client's access: it stores the write data, or it captures the addressed word into a read register. In the following cycle it raises that client's acknowledge. The acknowledge stays high until the client drops its request. The controller then spends at least one cycle idle before it grants anyone again. Every transfer is therefore a four-phase handshake.

The address is four bits wide, but only ten words exist. Writes to the six unused addresses are dropped, and reads from them return zero.

Top module: `shared_ram_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, both acknowledges are low after that edge. Reset does not change the storage contents.
- R2: From idle, a request from a single client is answered by that client's acknowledge one clock edge after the request is first sampled.
- R3: When both requests are high while the controller is idle, `b_ack` rises on the next edge and `a_ack` stays low.
- R4: An acknowledge stays high as long as the same client's request stays high.
- R5: After a client drops its request, its acknowledge falls on the next edge. Both acknowledges are then low for at least one cycle before any new grant.
- R6: A read returns the word most recently written to that address (addresses 0 to 9). The value appears on the granted client's read data for every cycle its acknowledge is high.
- R7: Exactly one access is performed per grant. Write-data changes while an acknowledge is held have no effect on the stored word, and read data stays stable while an acknowledge is held.
- R8: Writes to addresses 10 to 15 change no stored word, and reads from addresses 10 to 15 return 0.
- R9: A client's read data is 0 whenever its acknowledge is low, and also during the acknowledge of a write.
- R10: Contents written before a reset pulse read back unchanged after it.
- R11: With client A requesting continuously, A is granted as soon as B leaves its request low during an idle cycle, so alternating traffic completes for both clients.
- R12: The two acknowledges are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_req | input | 1 | Client A access request |
| a_wr | input | 1 | Client A select: 1 = write, 0 = read |
| a_addr | input | 4 | Client A word address |
| a_wdata | input | 8 | Client A write data |
| a_ack | output | 1 | Client A acknowledge |
| a_rdata | output | 8 | Client A read data, valid while `a_ack` is high for a read |
| b_req | input | 1 | Client B access request (higher priority) |
| b_wr | input | 1 | Client B select: 1 = write, 0 = read |
| b_addr | input | 4 | Client B word address |
| b_wdata | input | 8 | Client B write data |
| b_ack | output | 1 | Client B acknowledge |
| b_rdata | output | 8 | Client B read data, valid while `b_ack` is high for a read |

## Verification
The hardest case to reach is a waiting low-priority client during B's handshake. Client A's request must be observed through B's whole grant and the idle cycle after it. Only then is A served, never overlapping B. The bench gets there by raising both requests on the same falling edge. It then probes each of the following edges for B's grant, the shared idle gap and A's late grant. A second phase runs both clients back to back, each re-requesting right after it is released, so that A's completion shows it was not starved.

// File: rtl/sra_pkg.sv
package sra_pkg;
    // Arbiter states; acknowledges are decoded from these alone (Moore)
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SERVE_A = 2'd1,
        ST_SERVE_B = 2'd2
    } arb_state_e;
endpackage

// File: rtl/sra_arb_fsm.sv
// Fixed-priority Moore arbiter for two clients.
// Client B wins a tie. A grant lasts as long as the client's request
// stays high, and the FSM always passes through IDLE between grants.
// Assumes requests are synchronous to clk.
module sra_arb_fsm
    import sra_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    output logic launch,
    output logic pick_b,
    output logic ack_a,
    output logic ack_b
);

    arb_state_e state_q;
    arb_state_e state_d;

    // Next-state selection with fixed priority to client B
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_b) begin
                    state_d = ST_SERVE_B;
                end else if (req_a) begin
                    state_d = ST_SERVE_A;
                end
            end
            ST_SERVE_A: begin
                if (!req_a) state_d = ST_IDLE;
            end
            ST_SERVE_B: begin
                if (!req_b) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access strobe for the granting edge and the winner's identity
    assign launch = (state_q == ST_IDLE) && (req_a || req_b);
    assign pick_b = req_b;

    // Moore acknowledges decoded from the current state only
    assign ack_a = (state_q == ST_SERVE_A);
    assign ack_b = (state_q == ST_SERVE_B);

endmodule

// File: rtl/sra_port_sel.sv
// Routes the command fields of the winning client to the storage.
// Assumes pick_b is only used while a grant is being launched.
module sra_port_sel #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              pick_b,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              sel_wr,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [DATA_W-1:0] sel_wdata
);

    localparam int CMD_W = 1 + ADDR_W + DATA_W;

    logic [CMD_W-1:0] cmd_a;
    logic [CMD_W-1:0] cmd_b;
    logic [CMD_W-1:0] cmd_sel;

    assign cmd_a = {a_wr, a_addr, a_wdata};
    assign cmd_b = {b_wr, b_addr, b_wdata};

    // Two-way select of the packed command
    always_comb begin
        cmd_sel = pick_b ? cmd_b : cmd_a;
    end

    assign {sel_wr, sel_addr, sel_wdata} = cmd_sel;

endmodule

// File: rtl/sra_store.sv
// Single-port word store with a registered read port.
// One access happens on each cycle `en` is high. Addresses at or above
// DEPTH match no word: writes there are dropped and reads there give 0.
// Words have no reset; only the read register is cleared by rst_n.
module sra_store #(
    parameter int DEPTH  = 10,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_q
);

    logic [DEPTH-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]            rd_sel;

    // One register per word, each with its own address decode
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        logic [DATA_W-1:0] word_q;

        // Capture write data when this word is the write target
        always_ff @(posedge clk) begin
            if (en && wr && (addr == IDX)) begin
                word_q <= wdata;
            end
        end

        assign words[i] = word_q;
    end

    // Read selection; an address with no matching word yields zero
    always_comb begin
        rd_sel = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (addr == ADDR_W'(k)) rd_sel = words[k];
        end
    end

    // Read register: loaded once per access, zero for writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (en) begin
            rd_q <= wr ? '0 : rd_sel;
        end
    end

endmodule

// File: rtl/shared_ram_arbiter.sv
// Two-client shared byte store.
// A fixed-priority Moore arbiter (client B first) grants one
// four-phase handshake at a time. The access is performed on the
// granting edge, and acknowledge plus read data follow one cycle later.
// Assumes clients hold their command fields stable while requesting.
module shared_ram_arbiter #(
    parameter int DEPTH  = 10,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic              a_ack,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_req,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              b_ack,
    output logic [DATA_W-1:0] b_rdata
);

    logic              launch;
    logic              pick_b;
    logic              sel_wr;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [DATA_W-1:0] rd_q;

    sra_arb_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_a  (a_req),
        .req_b  (b_req),
        .launch (launch),
        .pick_b (pick_b),
        .ack_a  (a_ack),
        .ack_b  (b_ack)
    );

    sra_port_sel #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sel (
        .pick_b    (pick_b),
        .a_wr      (a_wr),
        .a_addr    (a_addr),
        .a_wdata   (a_wdata),
        .b_wr      (b_wr),
        .b_addr    (b_addr),
        .b_wdata   (b_wdata),
        .sel_wr    (sel_wr),
        .sel_addr  (sel_addr),
        .sel_wdata (sel_wdata)
    );

    sra_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (launch),
        .wr    (sel_wr),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rd_q  (rd_q)
    );

    // Read data reaches only the client currently acknowledged
    assign a_rdata = a_ack ? rd_q : '0;
    assign b_rdata = b_ack ? rd_q : '0;

endmodule

// File: rtl/sra_checker.sv
// Handshake and priority properties observed at the top-level ports.
module sra_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_req,
    input logic              a_ack,
    input logic [DATA_W-1:0] a_rdata,
    input logic              b_req,
    input logic              b_ack,
    input logic [DATA_W-1:0] b_rdata
);

    AST_RESET_DROPS_ACK: assert property (@(posedge clk)
        !rst_n |=> (!a_ack && !b_ack)); // R1

    AST_A_SOLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ack && !b_ack && a_req && !b_req) |=> a_ack); // R2

    AST_B_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ack && !b_ack && b_req) |=> (b_ack && !a_ack)); // R3

    AST_A_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ack && a_req) |=> a_ack); // R4

    AST_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_ack && b_req) |=> b_ack); // R4

    AST_A_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ack && !a_req) |=> (!a_ack && !b_ack)); // R5

    AST_B_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (b_ack && !b_req) |=> (!a_ack && !b_ack)); // R5

    AST_A_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        a_ack |=> (!a_ack || $stable(a_rdata))); // R7

    AST_B_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        b_ack |=> (!b_ack || $stable(b_rdata))); // R7

    AST_A_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !a_ack |-> (a_rdata == '0)); // R9

    AST_B_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !b_ack |-> (b_rdata == '0)); // R9

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ack && b_ack)); // R12

endmodule

bind shared_ram_arbiter sra_checker #(
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_req   (a_req),
    .a_ack   (a_ack),
    .a_rdata (a_rdata),
    .b_req   (b_req),
    .b_ack   (b_ack),
    .b_rdata (b_rdata)
);

// File: tb/shared_ram_arbiter_tb.sv
module shared_ram_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_req = 1'b0, a_wr = 1'b0, b_req = 1'b0, b_wr = 1'b0;
    logic [3:0] a_addr = '0, b_addr = '0;
    logic [7:0] a_wdata = '0, b_wdata = '0;
    logic       a_ack, b_ack;
    logic [7:0] a_rdata, b_rdata;

    int checks = 0;
    int fails  = 0;
    int done_a = 0;
    int done_b = 0;

    logic [7:0] model [16];
    logic [7:0] qa [$];
    logic [7:0] qb [$];
    logic       a_ack_d = 1'b0, b_ack_d = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    shared_ram_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_ack(a_ack), .a_rdata(a_rdata),
        .b_req(b_req), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_ack(b_ack), .b_rdata(b_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Driver: pushes the expected read data, then runs one four-phase handshake
    task automatic access(input bit is_b, input bit wr, input logic [3:0] addr,
                          input logic [7:0] d, input int hold);
        logic [7:0] exp;
        if (wr) begin
            exp = 8'h00;                         // R9: write ack shows zero
            if (addr < 4'd10) model[addr] = d;   // R8: high addresses dropped
        end else begin
            exp = (addr < 4'd10) ? model[addr] : 8'h00;
        end
        if (is_b) qb.push_back(exp); else qa.push_back(exp);
        @(negedge clk);
        if (is_b) begin
            b_req = 1'b1; b_wr = wr; b_addr = addr; b_wdata = d;
        end else begin
            a_req = 1'b1; a_wr = wr; a_addr = addr; a_wdata = d;
        end
        do @(negedge clk); while (!(is_b ? b_ack : a_ack));
        for (int k = 0; k < hold; k++) begin
            if (is_b) b_wdata = ~d; else a_wdata = ~d;
            @(negedge clk);
            chk(is_b ? b_ack : a_ack, "R4 ack held", 0, 1);
            chk((is_b ? b_rdata : a_rdata) == exp, "R7 rdata stable",
                is_b ? b_rdata : a_rdata, exp);
        end
        if (is_b) b_req = 1'b0; else a_req = 1'b0;
        @(negedge clk);
        chk(!(is_b ? b_ack : a_ack), "R5 ack falls", 1, 0);
        if (is_b) done_b++; else done_a++;
    endtask

    // Monitor: on each acknowledge rise, pop and compare the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (a_ack && !a_ack_d) begin
                chk(!b_ack, "R12 exclusive", 1, 0);
                if (qa.size() == 0) chk(1'b0, "R6 unexpected A grant", 1, 0);
                else begin
                    logic [7:0] e;
                    e = qa.pop_front();
                    chk(a_rdata == e, "R6 A read data", a_rdata, e);
                end
            end
            if (b_ack && !b_ack_d) begin
                chk(!a_ack, "R12 exclusive", 1, 0);
                if (qb.size() == 0) chk(1'b0, "R6 unexpected B grant", 1, 0);
                else begin
                    logic [7:0] e;
                    e = qb.pop_front();
                    chk(b_rdata == e, "R6 B read data", b_rdata, e);
                end
            end
        end
        a_ack_d <= a_ack;
        b_ack_d <= b_ack;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!a_ack && !b_ack, "R1 reset acks", {a_ack, b_ack}, 0);
        rst_n = 1'b1;

        // Fill the store from both clients
        for (int i = 0; i < 10; i++)
            access(i[0], 1'b1, 4'(i), 8'(8'h30 + i * 7), 0);

        // R2: sole request answered one edge later
        fork
            access(1'b0, 1'b0, 4'd0, 8'h00, 0);
            begin
                repeat (2) @(negedge clk);
                chk(a_ack, "R2 grant latency", a_ack, 1);
            end
        join
        for (int i = 1; i < 10; i++) access(1'b1, 1'b0, 4'(i), 8'h00, 0);

        // R7 / R4: write data changed while ack is held is not stored
        access(1'b1, 1'b1, 4'd3, 8'hA5, 3);
        access(1'b0, 1'b0, 4'd3, 8'h00, 2);

        // R8: high addresses
        access(1'b0, 1'b1, 4'd12, 8'hFF, 0);
        access(1'b1, 1'b1, 4'd15, 8'hEE, 0);
        access(1'b0, 1'b0, 4'd12, 8'h00, 0);
        access(1'b1, 1'b0, 4'd15, 8'h00, 0);
        access(1'b0, 1'b0, 4'd2, 8'h00, 0);

        // R3 / R5: simultaneous requests, B first, idle gap, then A
        fork
            access(1'b0, 1'b0, 4'd4, 8'h00, 0);
            access(1'b1, 1'b0, 4'd5, 8'h00, 0);
            begin
                repeat (2) @(negedge clk);
                chk(b_ack && !a_ack, "R3 B wins tie", {a_ack, b_ack}, 1);
                @(negedge clk);
                chk(!a_ack && !b_ack, "R5 idle gap", {a_ack, b_ack}, 0);
                @(negedge clk);
                chk(a_ack, "R5 A served after gap", a_ack, 1);
            end
        join

        // R10: reset pulse keeps stored words
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!a_ack && !b_ack, "R1 reset acks", {a_ack, b_ack}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) access(1'b0, 1'b0, 4'(i), 8'h00, 0);
        chk(1'b1, "R10 contents kept (compared by monitor)", 0, 0);

        // R11: back-to-back traffic from both clients completes
        done_a = 0;
        done_b = 0;
        fork
            for (int i = 0; i < 4; i++) access(1'b0, 1'b0, 4'(i), 8'h00, 0);
            for (int i = 0; i < 4; i++) access(1'b1, 1'b1, 4'(6 + i), 8'(8'h90 + i), 0);
        join
        chk(done_a == 4, "R11 A completes", done_a, 4);
        chk(done_b == 4, "R11 B completes", done_b, 4);
        for (int i = 6; i < 10; i++) access(1'b0, 1'b0, 4'(i), 8'h00, 0);

        // R9: no ack, read data quiet
        @(negedge clk);
        chk(a_rdata == 8'h00, "R9 A rdata idle", a_rdata, 0);
        chk(b_rdata == 8'h00, "R9 B rdata idle", b_rdata, 0);
        chk(qa.size() == 0 && qb.size() == 0, "R6 scoreboard drained",
            qa.size() + qb.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule